// File: doc/BRIEF.md
# Sleep Wake-Up Clock Sequencer

This block decides when a small processor core may run again after a low-power sleep, and which clock drives it once it does. The core raises a sleep request. The sequencer then holds the core stopped until an enabled interrupt source fires. At that moment it captures the 2-bit clock select field. That captured value alone decides the exit path. Waking onto the primary clock with a crystal or resonator oscillator runs an oscillator start-up count of primary-clock ticks alongside the CPU start-up count, and the core is released only when both have finished. Waking onto the secondary or internal clock waits for the CPU start-up count only.

Both counts advance on tick inputs, not on the sequencer's own clock. The CPU start-up count advances on a start-up timebase tick. The oscillator count advances on a tick for each primary-oscillator cycle. With two-speed start-up enabled, a primary-clock wake lets the core run from the internal clock as soon as the CPU count is done. The core moves to the primary clock when the oscillator count completes. If the clock select field is set to primary while the core is awake on another clock, the switch is deferred until after the next sleep and its oscillator start-up.

Top module: `wake_clk_seq`

## Requirements
- R1: After reset the sequencer is awake: `asleep_o`=0, `core_run_o`=1 and `clk_src_o`=00 (primary).
- R2: A sleep request while awake, with no enabled wake event in that cycle, gives `asleep_o`=1 and `core_run_o`=0 from the next cycle on. This holds until an enabled wake event arrives.
- R3: A wake event is any bit set in both `wake_src_i` and `wake_en_i`. While asleep, an enabled event starts the exit sequence, and a source whose enable bit is 0 leaves the sequencer asleep.
- R4: After a wake the core stays held until `CST_TICKS` start-up ticks (`cst_tick_i`) have been counted.
- R5: A wake with select 00 and `osc_mode_i` of 00, 01 or 10 (crystal or resonator modes) also counts `OST_TICKS` primary ticks (`pri_tick_i`) in parallel. Without two-speed start-up, release waits for both counts and the core then runs with `clk_src_o`=00.
- R6: A wake with select 00 and `osc_mode_i`=11 (no start-up needed) is gated by the CPU start-up count alone and exits on `clk_src_o`=00.
- R7: A wake with select 01 is gated by the CPU count alone and exits on the secondary clock (`clk_src_o`=01). Select 10 and 11 do the same and exit on the internal clock (`clk_src_o`=10).
- R8: With two-speed start-up (`two_speed_i`=1) and a wake that needs the oscillator count, the core runs on the internal clock once the CPU count is done. `clk_src_o` becomes 00 in the cycle the oscillator count completes.
- R9: The select field is sampled at the wake event. Changes to it during the start-up wait do not alter the exit path.
- R10: While awake, a nonzero select takes effect on `clk_src_o` in the next cycle. A change to 00 while not on the primary clock keeps the current clock until sleep, and the next wake switches to primary only after the oscillator count.
- R11: Both counts restart from zero on every sleep entry. This includes a sleep taken while running on the internal clock during a two-speed start-up.
- R12: A wake event while awake changes nothing. A sleep request in the same cycle as an enabled wake event is abandoned and the sequencer stays awake.
- R13: The counts advance only on cycles with their tick input high. With a tick held low the core stays held indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Core asks to enter sleep |
| wake_src_i | input | N_WAKE | Interrupt wake sources |
| wake_en_i | input | N_WAKE | Per-source wake enable |
| clk_sel_i | input | 2 | Clock select: 00 primary, 01 secondary, 1x internal |
| osc_mode_i | input | 2 | Primary oscillator mode; 11 needs no start-up count |
| two_speed_i | input | 1 | Two-speed start-up enable |
| pri_tick_i | input | 1 | One pulse per primary-oscillator cycle |
| cst_tick_i | input | 1 | CPU start-up timebase tick |
| asleep_o | output | 1 | Core held in sleep |
| core_run_o | output | 1 | Core may execute |
| clk_src_o | output | 2 | Clock driving the core: 00 primary, 01 secondary, 10 internal |

## Verification
Two pairs of events can fall in one cycle. The first pair is a sleep request and an enabled wake event. The bench drives both in the same cycle and expects the sequencer to remain awake, with the sleep abandoned. The second pair is a sleep request during a two-speed start-up and the ongoing oscillator count. After a second wake the bench expects the primary clock only after a full fresh count, not a count resumed from where it stopped. A sweep over every select, oscillator mode and two-speed setting compares the release cycle, the clock at release and the first primary-clock cycle against values computed from the two count lengths.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

   typedef enum logic [1:0] {
      ST_AWAKE = 2'b00,
      ST_SLEEP = 2'b01,
      ST_WAKE  = 2'b10
   } seq_state_e;

   typedef enum logic [1:0] {
      SRC_PRI = 2'b00,
      SRC_SEC = 2'b01,
      SRC_INT = 2'b10
   } clk_src_e;

   // Select 11 is folded onto the internal clock.
   function automatic clk_src_e sel_to_src(input logic [1:0] sel);
      clk_src_e r;
      case (sel)
         2'b00:   r = SRC_PRI;
         2'b01:   r = SRC_SEC;
         default: r = SRC_INT;
      endcase
      return r;
   endfunction

   // Crystal and resonator modes need the oscillator start-up count.
   function automatic logic osc_needs_ost(input logic [1:0] mode);
      return (mode != 2'b11);
   endfunction

endpackage

// File: rtl/wake_tick_timer.sv
module wake_tick_timer #(
   parameter int unsigned LEN = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic run_i,
   input  logic tick_i,
   output logic done_o
);

   localparam int unsigned CW = (LEN > 1) ? $clog2(LEN + 1) : 1;

   if (LEN < 1) begin : g_bad_len
      $error("wake_tick_timer: LEN must be at least 1");
   end

   if (LEN == 1) begin : g_flag
      logic hit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                hit_q <= 1'b0;
         else if (clear_i)           hit_q <= 1'b0;
         else if (run_i && tick_i)   hit_q <= 1'b1;
      end
      assign done_o = hit_q;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      logic          full;
      assign full = (cnt_q == CW'(LEN));
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                       cnt_q <= '0;
         else if (clear_i)                  cnt_q <= '0;
         else if (run_i && tick_i && !full) cnt_q <= cnt_q + 1'b1;
      end
      assign done_o = full;
   end

endmodule

// File: rtl/wake_exit_fsm.sv
module wake_exit_fsm
   import wake_seq_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       sleep_req_i,
   input  logic       wake_any_i,
   input  logic [1:0] clk_sel_i,
   input  logic [1:0] osc_mode_i,
   input  logic       two_speed_i,
   input  logic       cst_done_i,
   input  logic       ost_done_i,
   output seq_state_e state_o,
   output logic       timer_clear_o,
   output logic       timer_run_o,
   output logic       need_ost_o,
   output logic       asleep_o,
   output clk_src_e   exit_src_o
);

   seq_state_e state_q, state_d;
   logic [1:0] sel_q;
   logic       pri_ready, released, enter;

   assign need_ost_o = (sel_q == 2'b00) && osc_needs_ost(osc_mode_i);
   assign pri_ready  = !need_ost_o || ost_done_i;
   assign released   = cst_done_i && (pri_ready || two_speed_i);
   assign enter      = sleep_req_i && !wake_any_i &&
                       ((state_q == ST_AWAKE) || ((state_q == ST_WAKE) && released));

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_AWAKE: if (enter) state_d = ST_SLEEP;
         ST_SLEEP: if (wake_any_i) state_d = ST_WAKE;
         ST_WAKE: begin
            if (enter)                         state_d = ST_SLEEP;
            else if (cst_done_i && pri_ready)  state_d = ST_AWAKE;
         end
         default: state_d = ST_AWAKE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_AWAKE;
         sel_q   <= 2'b00;
      end else begin
         state_q <= state_d;
         if ((state_q == ST_SLEEP) && wake_any_i) sel_q <= clk_sel_i;
      end
   end

   assign state_o       = state_q;
   assign timer_clear_o = enter;
   assign timer_run_o   = (state_q == ST_WAKE);
   assign asleep_o      = (state_q == ST_SLEEP) || ((state_q == ST_WAKE) && !released);
   assign exit_src_o    = ((sel_q == 2'b00) && !pri_ready) ? SRC_INT : sel_to_src(sel_q);

endmodule

// File: rtl/wake_clk_route.sv
module wake_clk_route
   import wake_seq_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  seq_state_e state_i,
   input  logic [1:0] clk_sel_i,
   input  clk_src_e   exit_src_i,
   output logic [1:0] clk_src_o
);

   clk_src_e src_q;

   // While awake a request for the primary clock is deferred to the next wake.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         src_q <= SRC_PRI;
      end else begin
         case (state_i)
            ST_AWAKE: if (clk_sel_i != 2'b00) src_q <= sel_to_src(clk_sel_i);
            ST_WAKE:  src_q <= exit_src_i;
            default:  src_q <= src_q;
         endcase
      end
   end

   assign clk_src_o = (state_i == ST_WAKE) ? exit_src_i : src_q;

endmodule

// File: rtl/wake_clk_seq.sv
module wake_clk_seq
   import wake_seq_pkg::*;
#(
   parameter int unsigned N_WAKE    = 4,
   parameter int unsigned CST_TICKS = 8,
   parameter int unsigned OST_TICKS = 1024
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sleep_req_i,
   input  logic [N_WAKE-1:0] wake_src_i,
   input  logic [N_WAKE-1:0] wake_en_i,
   input  logic [1:0]        clk_sel_i,
   input  logic [1:0]        osc_mode_i,
   input  logic              two_speed_i,
   input  logic              pri_tick_i,
   input  logic              cst_tick_i,
   output logic              asleep_o,
   output logic              core_run_o,
   output logic [1:0]        clk_src_o
);

   if (N_WAKE < 1) begin : g_bad_nwake
      $error("wake_clk_seq: N_WAKE must be at least 1");
   end
   if (OST_TICKS < 1 || CST_TICKS < 1) begin : g_bad_ticks
      $error("wake_clk_seq: start-up lengths must be nonzero");
   end

   seq_state_e state_w;
   clk_src_e   exit_src_w;
   logic       wake_any_w, clear_w, run_w, need_ost_w, cst_done_w, ost_done_w, asleep_w;

   assign wake_any_w = |(wake_src_i & wake_en_i);

   wake_tick_timer #(.LEN(CST_TICKS)) u_cst (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_w),
      .run_i   (run_w),
      .tick_i  (cst_tick_i),
      .done_o  (cst_done_w)
   );

   wake_tick_timer #(.LEN(OST_TICKS)) u_ost (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_w),
      .run_i   (run_w && need_ost_w),
      .tick_i  (pri_tick_i),
      .done_o  (ost_done_w)
   );

   wake_exit_fsm u_fsm (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .sleep_req_i   (sleep_req_i),
      .wake_any_i    (wake_any_w),
      .clk_sel_i     (clk_sel_i),
      .osc_mode_i    (osc_mode_i),
      .two_speed_i   (two_speed_i),
      .cst_done_i    (cst_done_w),
      .ost_done_i    (ost_done_w),
      .state_o       (state_w),
      .timer_clear_o (clear_w),
      .timer_run_o   (run_w),
      .need_ost_o    (need_ost_w),
      .asleep_o      (asleep_w),
      .exit_src_o    (exit_src_w)
   );

   wake_clk_route u_route (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .state_i    (state_w),
      .clk_sel_i  (clk_sel_i),
      .exit_src_i (exit_src_w),
      .clk_src_o  (clk_src_o)
   );

   assign asleep_o   = asleep_w;
   assign core_run_o = !asleep_w;

endmodule

// File: rtl/wake_clk_seq_chk.sv
module wake_clk_seq_chk
   import wake_seq_pkg::*;
(
   input logic       clk_i,
   input logic       rst_ni,
   input logic       sleep_req_i,
   input logic       wake_any_i,
   input logic       two_speed_i,
   input logic       asleep_o,
   input logic       core_run_o,
   input logic [1:0] clk_src_o,
   input logic       cst_done_i,
   input logic       ost_done_i,
   input logic       need_ost_i,
   input seq_state_e state_i
);

   assert_release_after_cst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(core_run_o) |-> cst_done_i);

   assert_ost_gates_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(core_run_o) && need_ost_i && !two_speed_i) |-> ost_done_i);

   assert_primary_after_ost_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clk_src_o == 2'b00) && ($past(clk_src_o) != 2'b00)) |-> (!need_ost_i || ost_done_i));

   assert_stay_awake_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((state_i == ST_AWAKE) && (!sleep_req_i || wake_any_i)) |=> (state_i == ST_AWAKE));

   assert_hold_in_sleep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((state_i == ST_SLEEP) && !wake_any_i) |=> (asleep_o && !core_run_o));

   assert_wake_leaves_sleep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((state_i == ST_SLEEP) && wake_any_i) |=> (state_i == ST_WAKE));

endmodule

bind wake_clk_seq wake_clk_seq_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .sleep_req_i (sleep_req_i),
   .wake_any_i  (wake_any_w),
   .two_speed_i (two_speed_i),
   .asleep_o    (asleep_o),
   .core_run_o  (core_run_o),
   .clk_src_o   (clk_src_o),
   .cst_done_i  (cst_done_w),
   .ost_done_i  (ost_done_w),
   .need_ost_i  (need_ost_w),
   .state_i     (state_w)
);

// File: tb/wake_clk_seq_tb_top.sv
module wake_clk_seq_tb_top;

   localparam int NW  = 4;
   localparam int CST = 8;
   localparam int OST = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_req = 1'b0;
   logic [NW-1:0] wake_src = '0;
   logic [NW-1:0] wake_en = 4'b0101;
   logic [1:0]    clk_sel = 2'b00;
   logic [1:0]    osc_mode = 2'b00;
   logic          two_speed = 1'b0;
   logic          pri_tick = 1'b1;
   logic          cst_tick = 1'b1;
   logic          asleep, core_run;
   logic [1:0]    clk_src;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   wake_clk_seq #(.N_WAKE(NW), .CST_TICKS(CST), .OST_TICKS(OST)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .sleep_req_i (sleep_req),
      .wake_src_i  (wake_src),
      .wake_en_i   (wake_en),
      .clk_sel_i   (clk_sel),
      .osc_mode_i  (osc_mode),
      .two_speed_i (two_speed),
      .pri_tick_i  (pri_tick),
      .cst_tick_i  (cst_tick),
      .asleep_o    (asleep),
      .core_run_o  (core_run),
      .clk_src_o   (clk_src)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic go_sleep();
      @(negedge clk) sleep_req = 1'b1;
      @(negedge clk) sleep_req = 1'b0;
   endtask

   task automatic pulse_wake(input logic [NW-1:0] m);
      @(negedge clk) wake_src = m;
      @(negedge clk) wake_src = '0;
   endtask

   // Entered on the first negedge after the wake edge (sample index 0).
   task automatic measure(input int flip_at, input logic [1:0] flip_sel,
                          output int rel, output int pri, output int src_rel);
      rel = -1; pri = -1; src_rel = -1;
      for (int j = 0; j < OST + 6; j++) begin
         if (j == flip_at) clk_sel = flip_sel;
         if (rel < 0 && core_run) begin rel = j; src_rel = int'(clk_src); end
         if (pri < 0 && core_run && clk_src == 2'b00) pri = j;
         @(negedge clk);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000 && !finished) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int rel, pri, srel, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 asleep", int'(asleep), 0);
      chk("R1 run", int'(core_run), 1);
      chk("R1 src", int'(clk_src), 0);

      // Sweep every select, oscillator mode and two-speed setting
      for (int cfg = 0; cfg < 32; cfg++) begin
         int  sel  = cfg / 8;
         int  mode = (cfg / 2) % 4;
         int  ts   = cfg % 2;
         bit  need = (sel == 0) && (mode != 3);
         @(negedge clk);
         clk_sel = 2'(sel); osc_mode = 2'(mode); two_speed = ts[0];
         go_sleep();
         chk("R2 asleep after request", int'(asleep), 1);
         pulse_wake((cfg % 2 == 0) ? 4'b0001 : 4'b0100);
         measure(-1, 2'b00, rel, pri, srel);
         // R4 R5 R6 R7 R8 release point and clock at release
         chk(need && !ts ? "R5 release" : "R4 release", rel, (need && !ts) ? OST : CST);
         chk(sel == 0 ? (need && ts ? "R8 src at release" : "R6 src at release") : "R7 src at release",
             srel, (sel == 0) ? ((need && ts) ? 2 : 0) : ((sel == 1) ? 1 : 2));
         if (sel == 0) chk(need ? "R8 first primary" : "R6 first primary", pri, need ? OST : CST);
         chk("R7 final src", int'(clk_src), (sel == 0) ? 0 : ((sel == 1) ? 1 : 2));
      end

      // R3 disabled source does not wake
      @(negedge clk); clk_sel = 2'b01; osc_mode = 2'b00; two_speed = 1'b0;
      go_sleep();
      pulse_wake(4'b0010);
      repeat (5) @(negedge clk);
      chk("R3 disabled source", int'(asleep), 1);
      pulse_wake(4'b0100);
      measure(-1, 2'b00, rel, pri, srel);
      chk("R3 enabled source release", rel, CST);

      // R9 select change during the wait is ignored
      go_sleep();
      pulse_wake(4'b0001);
      measure(2, 2'b00, rel, pri, srel);
      chk("R9 release", rel, CST);
      chk("R9 src at release", srel, 1);
      // R10 awake with select 00 while on secondary: stays secondary
      repeat (4) @(negedge clk);
      chk("R10 deferred", int'(clk_src), 1);
      go_sleep();
      pulse_wake(4'b0001);
      measure(-1, 2'b00, rel, pri, srel);
      chk("R10 primary after ost", pri, OST);
      // R10 nonzero select applies next cycle
      @(negedge clk) clk_sel = 2'b01;
      @(negedge clk);
      chk("R10 switch to secondary", int'(clk_src), 1);
      clk_sel = 2'b00;
      repeat (3) @(negedge clk);
      chk("R10 held secondary", int'(clk_src), 1);

      // R11 sleep during two-speed running restarts both counts
      two_speed = 1'b1;
      go_sleep();
      pulse_wake(4'b0001);
      repeat (100) @(negedge clk);
      chk("R11 running internal", int'(clk_src), 2);
      chk("R11 running", int'(core_run), 1);
      go_sleep();
      chk("R11 asleep", int'(asleep), 1);
      pulse_wake(4'b0001);
      measure(-1, 2'b00, rel, pri, srel);
      chk("R11 release", rel, CST);
      chk("R11 fresh ost", pri, OST);
      two_speed = 1'b0;

      // R12 wake while awake, and sleep with wake in the same cycle
      @(negedge clk);
      n = int'(clk_src);
      pulse_wake(4'b0001);
      chk("R12 wake awake asleep", int'(asleep), 0);
      chk("R12 wake awake src", int'(clk_src), n);
      @(negedge clk) begin sleep_req = 1'b1; wake_src = 4'b0100; end
      @(negedge clk) begin sleep_req = 1'b0; wake_src = '0; end
      chk("R12 abandoned sleep", int'(asleep), 0);
      repeat (3) @(negedge clk);
      chk("R12 still running", int'(core_run), 1);

      // R13 primary ticks gate the oscillator count
      clk_sel = 2'b00; osc_mode = 2'b01; pri_tick = 1'b0;
      go_sleep();
      pulse_wake(4'b0001);
      repeat (1100) @(negedge clk);
      chk("R13 held without pri ticks", int'(asleep), 1);
      pri_tick = 1'b1;
      n = 0;
      while (asleep && n < 3000) begin n++; @(negedge clk); end
      chk("R13 release after ticks", n, OST);
      // R13 start-up timebase ticks gate the CPU count
      @(negedge clk) begin clk_sel = 2'b01; cst_tick = 1'b0; end
      go_sleep();
      pulse_wake(4'b0001);
      repeat (20) @(negedge clk);
      chk("R13 held without cst ticks", int'(asleep), 1);
      cst_tick = 1'b1;
      n = 0;
      while (asleep && n < 3000) begin n++; @(negedge clk); end
      chk("R13 cst release", n, CST);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule